// File: doc/BRIEF.md
# Reconfigurable Macrocell Storage Stage

This block is the output stage of one programmable-logic cell. A static configuration selects what the stage does with its data bit. It can pass the bit straight through as a combinational output. It can store the bit in a D flip-flop, use it as the toggle control of a T flip-flop, or hold it in a transparent level-sensitive latch. The data bit comes from the cell's sum-of-products term, or from the pin in fast-input mode.

The storage element is clocked by one of several global clocks or by a locally generated product-term clock. The choice is made per cell. An optional dual-edge setting makes the element capture on both the rising and the falling edge of the chosen clock. It is built from two single-edge registers and a level-driven output mux.

A clock enable can block every capture. Asynchronous reset and preset come from a global source and from a per-cell source. A power-on input loads a configurable initial value. Configuration inputs are treated as static: they change only while every clock input is low, and each change is followed by a reset.

Top module: `cell_register`

## Requirements
- R1: With `cfg_mode` = 0 (bypass), `q_out` equals the selected data bit combinationally. Clocks, resets and presets have no effect on it.
- R2: With `cfg_mode` = 1 (D flip-flop), `q_out` takes the data bit at each rising edge of the selected clock and holds it between edges, including across falling edges when dual-edge is off.
- R3: With `cfg_mode` = 2 (T flip-flop), each active edge inverts the stored bit when the data bit is 1 and leaves it unchanged when it is 0.
- R4: With `cfg_mode` = 3 (latch), `q_out` follows the data bit while the selected clock is high and holds the last value while it is low.
- R5: `cfg_clk_pick` values 0 to 2 select `gclk[0]` to `gclk[2]`, and the value 3 selects `pt_clk`. Edges on the clocks that are not selected cause no capture.
- R6: With `cfg_both_edges` = 1, the D and T modes capture on both the rising and the falling edge of the selected clock.
- R7: With `cfg_fast_in` = 1, the data bit is `pin_in` instead of `sop_in`, in every mode including bypass.
- R8: While `clk_en` is 0, no capture happens in D, T or latch mode, and the stored value holds.
- R9: `glb_reset` or `cell_reset` forces the stored value to 0 at once, without a clock edge, in every storing mode.
- R10: `glb_preset` or `cell_preset` forces the stored value to 1 at once and overrides clocked capture. Reset wins when reset and preset are both high. If the reset is released while a preset is still held, the value becomes 1.
- R11: While `por_n` is 0, the stored value equals `init_val`, and any reset or preset is overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NUM_GCLK (3) | Global clock inputs |
| pt_clk | input | 1 | Locally generated product-term clock |
| por_n | input | 1 | Power-on load, active low |
| init_val | input | 1 | Value loaded while `por_n` is low |
| cfg_mode | input | 2 | 0 bypass, 1 D flip-flop, 2 T flip-flop, 3 latch |
| cfg_clk_pick | input | 2 | Clock source: 0..2 global, 3 product term |
| cfg_both_edges | input | 1 | Capture on both clock edges |
| cfg_fast_in | input | 1 | Take the data bit from the pin |
| sop_in | input | 1 | Sum-of-products data bit |
| pin_in | input | 1 | Pin data bit for fast-input mode |
| clk_en | input | 1 | Clock enable, active high |
| glb_reset | input | 1 | Global asynchronous reset |
| glb_preset | input | 1 | Global asynchronous preset |
| cell_reset | input | 1 | Per-cell asynchronous reset |
| cell_preset | input | 1 | Per-cell asynchronous preset |
| q_out | output | 1 | Stage output |

## Verification
Bypass, latch-transparent, reset, preset and power-on results are combinational. The bench samples them 1 to 2 ns after the input that causes them, with no clock edge in between. Clocked results are due at the selected edge itself. So the bench settles the data bit 2 ns before each edge, moves only one clock input at a time, and samples 3 ns after the edge, before any other input moves. The checks made with no edge are the ones that prove a captured value holds: after a data change while the clock is high, after a falling edge in single-edge mode, and after edges on unselected clocks.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_DFF    = 2'd1,
    MODE_TFF    = 2'd2,
    MODE_LATCH  = 2'd3
  } cell_mode_e;

  // Asynchronous clear request: power-on load of 0, otherwise any reset.
  function automatic logic force_low(input logic por_n, input logic init,
                                     input logic rst);
    return por_n ? rst : !init;
  endfunction

  // Asynchronous set request: power-on load of 1, otherwise preset without reset.
  function automatic logic force_high(input logic por_n, input logic init,
                                      input logic rst, input logic pre);
    return por_n ? (!rst && pre) : init;
  endfunction

  // Value captured at an active edge given the value currently shown.
  function automatic logic next_bit(input cell_mode_e m, input logic held,
                                    input logic din, input logic en);
    if (!en) return held;
    if (m == MODE_TFF) return held ^ din;
    return din;
  endfunction

endpackage

// File: rtl/cell_clk_pick.sv
module cell_clk_pick #(
  parameter int NUM_GCLK = 3,
  localparam int PICK_W = $clog2(NUM_GCLK + 1),
  localparam int NSRC = NUM_GCLK + 1
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                pt_clk,
  input  logic [PICK_W-1:0]   pick,
  output logic                clk_out
);
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] hit;

  assign src = {pt_clk, gclk};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src[i] && (pick == PICK_W'(i));
  end

  assign clk_out = |hit;
endmodule

// File: rtl/cell_edge_reg.sv
module cell_edge_reg
  import cell_pkg::*;
#(
  parameter bit DUAL_EDGE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       set,
  input  cell_mode_e mode,
  input  logic       din,
  input  logic       en,
  input  logic       dual,
  output logic       q
);
  logic pos_r, neg_r, dual_on, held_pos, pos_nxt, quiet;

  assign dual_on  = DUAL_EDGE_EN && dual;
  assign held_pos = dual_on ? neg_r : pos_r;
  assign pos_nxt  = next_bit(mode, held_pos, din, en);

  always_ff @(posedge clk or posedge clr or posedge set) begin
    if (clr)      pos_r <= 1'b0;
    else if (set) pos_r <= 1'b1;
    else          pos_r <= pos_nxt;
  end

  if (DUAL_EDGE_EN) begin : g_dual
    logic neg_nxt;
    assign neg_nxt = next_bit(mode, pos_r, din, en);
    always_ff @(negedge clk or posedge clr or posedge set) begin
      if (clr)      neg_r <= 1'b0;
      else if (set) neg_r <= 1'b1;
      else          neg_r <= neg_nxt;
    end
    assign q = dual_on ? (clk ? pos_r : neg_r) : pos_r;
  end else begin : g_single
    assign neg_r = pos_r;
    assign q     = pos_r;
  end

  // Marks edge intervals free of any asynchronous force, for the checks below.
  always_ff @(posedge clk or posedge clr or posedge set) begin
    if (clr || set) quiet <= 1'b0;
    else            quiet <= 1'b1;
  end

  // R2
  d_capture_chk: assert property (@(posedge clk) disable iff (clr || set)
    (quiet && $past(en && mode == MODE_DFF && !dual_on)) |-> (pos_r == $past(din)));

  // R3
  t_toggle_chk: assert property (@(posedge clk) disable iff (clr || set)
    (quiet && $past(en && mode == MODE_TFF && !dual_on)) |->
      (pos_r == ($past(pos_r) ^ $past(din))));

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (clr || set)
    (quiet && $past(!en && !dual_on)) |-> (pos_r == $past(pos_r)));
endmodule

// File: rtl/cell_latch.sv
module cell_latch (
  input  logic clk,
  input  logic en,
  input  logic clr,
  input  logic set,
  input  logic din,
  output logic q
);
  logic open_w;
  assign open_w = clk && en;

  always_latch begin
    if (clr)         q = 1'b0;
    else if (set)    q = 1'b1;
    else if (open_w) q = din;
  end

  // R4
  latch_open_chk: assert property (@(negedge clk) disable iff (clr || set)
    en |-> (q == din));
endmodule

// File: rtl/cell_register.sv
module cell_register
  import cell_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  parameter bit DUAL_EDGE_EN = 1'b1,
  localparam int PICK_W = $clog2(NUM_GCLK + 1)
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                pt_clk,
  input  logic                por_n,
  input  logic                init_val,
  input  logic [1:0]          cfg_mode,
  input  logic [PICK_W-1:0]   cfg_clk_pick,
  input  logic                cfg_both_edges,
  input  logic                cfg_fast_in,
  input  logic                sop_in,
  input  logic                pin_in,
  input  logic                clk_en,
  input  logic                glb_reset,
  input  logic                glb_preset,
  input  logic                cell_reset,
  input  logic                cell_preset,
  output logic                q_out
);
  cell_mode_e mode;
  logic sel_clk, any_rst, any_pre, clr, set, d_src, ff_q, lat_q;

  assign mode    = cell_mode_e'(cfg_mode);
  assign d_src   = cfg_fast_in ? pin_in : sop_in;
  assign any_rst = glb_reset || cell_reset;
  assign any_pre = glb_preset || cell_preset;
  assign clr     = force_low(por_n, init_val, any_rst);
  assign set     = force_high(por_n, init_val, any_rst, any_pre);

  cell_clk_pick #(.NUM_GCLK(NUM_GCLK)) u_pick (
    .gclk    (gclk),
    .pt_clk  (pt_clk),
    .pick    (cfg_clk_pick),
    .clk_out (sel_clk)
  );

  cell_edge_reg #(.DUAL_EDGE_EN(DUAL_EDGE_EN)) u_ff (
    .clk  (sel_clk),
    .clr  (clr),
    .set  (set),
    .mode (mode),
    .din  (d_src),
    .en   (clk_en),
    .dual (cfg_both_edges),
    .q    (ff_q)
  );

  cell_latch u_lat (
    .clk (sel_clk),
    .en  (clk_en),
    .clr (clr),
    .set (set),
    .din (d_src),
    .q   (lat_q)
  );

  always_comb begin
    unique case (mode)
      MODE_BYPASS: q_out = d_src;
      MODE_LATCH:  q_out = lat_q;
      default:     q_out = ff_q;
    endcase
  end

  // R9
  reset_force_chk: assert property (@(posedge sel_clk) disable iff (!por_n)
    (any_rst && mode != MODE_BYPASS) |-> (q_out == 1'b0));

  // R10
  preset_force_chk: assert property (@(posedge sel_clk) disable iff (!por_n)
    (!any_rst && any_pre && mode != MODE_BYPASS) |-> (q_out == 1'b1));
endmodule

// File: tb/sim_cell_register.sv
module sim_cell_register;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] cks;
  logic por_n, init_val, cfg_both_edges, cfg_fast_in, sop_in, pin_in, clk_en;
  logic glb_reset, glb_preset, cell_reset, cell_preset, q_out;
  logic [1:0] cfg_mode, cfg_clk_pick;

  int n_cmp = 0;
  int n_bad = 0;
  int ticks = 0;
  bit done = 0;

  cell_register u0 (
    .gclk(cks[2:0]), .pt_clk(cks[3]), .por_n(por_n), .init_val(init_val),
    .cfg_mode(cfg_mode), .cfg_clk_pick(cfg_clk_pick),
    .cfg_both_edges(cfg_both_edges), .cfg_fast_in(cfg_fast_in),
    .sop_in(sop_in), .pin_in(pin_in), .clk_en(clk_en),
    .glb_reset(glb_reset), .glb_preset(glb_preset),
    .cell_reset(cell_reset), .cell_preset(cell_preset), .q_out(q_out)
  );

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic exp);
    n_cmp++;
    if (q_out !== exp) begin
      n_bad++;
      $display("FAIL %s: q_out actual %b expected %b", tag, q_out, exp);
    end
  endtask

  task automatic rise(input int i);
    cks[i] = 1'b1; #3;
  endtask

  task automatic fall(input int i);
    cks[i] = 1'b0; #3;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] p,
                       input logic dual, input logic fast);
    cks = '0; #1;
    cfg_mode = m; cfg_clk_pick = p; cfg_both_edges = dual; cfg_fast_in = fast;
    clk_en = 1'b1; sop_in = 1'b0; pin_in = 1'b0;
    cell_reset = 1'b1; #2; cell_reset = 1'b0; #2;
  endtask

  task automatic t_powerup();
    chk("R11 init 1 while por low", 1'b1);
    glb_reset = 1'b1; #2;
    chk("R11 por beats reset", 1'b1);
    glb_reset = 1'b0; por_n = 1'b1; #2;
    chk("R11 value kept after por", 1'b1);
    init_val = 1'b0; por_n = 1'b0; #2;
    chk("R11 init 0 while por low", 1'b0);
    por_n = 1'b1; #2;
    chk("R11 init 0 after por", 1'b0);
  endtask

  task automatic t_bypass();
    setup(2'd0, 2'd0, 1'b0, 1'b0);
    sop_in = 1'b1; #1; chk("R1 bypass follows 1", 1'b1);
    sop_in = 1'b0; #1; chk("R1 bypass follows 0", 1'b0);
    sop_in = 1'b1; glb_reset = 1'b1; #1;
    chk("R1 reset ignored in bypass", 1'b1);
    glb_reset = 1'b0; rise(0);
    sop_in = 1'b0; #1; chk("R1 clock ignored in bypass", 1'b0);
    fall(0);
  endtask

  task automatic t_fast();
    setup(2'd0, 2'd0, 1'b0, 1'b1);
    pin_in = 1'b1; sop_in = 1'b0; #1; chk("R7 bypass uses pin 1", 1'b1);
    pin_in = 1'b0; sop_in = 1'b1; #1; chk("R7 bypass uses pin 0", 1'b0);
    setup(2'd1, 2'd0, 1'b0, 1'b1);
    pin_in = 1'b1; sop_in = 1'b0; #2; rise(0);
    chk("R7 register captures pin 1", 1'b1);
    fall(0);
    pin_in = 1'b0; sop_in = 1'b1; #2; rise(0);
    chk("R7 register captures pin 0", 1'b0);
    fall(0);
  endtask

  task automatic t_dff();
    setup(2'd1, 2'd0, 1'b0, 1'b0);
    chk("R2 after setup", 1'b0);
    sop_in = 1'b1; #2; chk("R2 no capture without edge", 1'b0);
    rise(0); chk("R2 rising capture 1", 1'b1);
    sop_in = 1'b0; #2; chk("R2 hold while clock high", 1'b1);
    fall(0); chk("R2 falling edge no capture", 1'b1);
    rise(0); chk("R2 rising capture 0", 1'b0);
    fall(0);
  endtask

  task automatic t_pick();
    for (int p = 0; p < 4; p++) begin
      setup(2'd1, 2'(p), 1'b0, 1'b0);
      sop_in = 1'b1; #2;
      for (int j = 0; j < 4; j++) begin
        if (j != p) begin
          rise(j); fall(j);
        end
      end
      chk($sformatf("R5 pick %0d other clocks ignored", p), 1'b0);
      rise(p);
      chk($sformatf("R5 pick %0d own clock captures", p), 1'b1);
      fall(p);
    end
  endtask

  task automatic t_tff();
    setup(2'd2, 2'd1, 1'b0, 1'b0);
    sop_in = 1'b1; #2;
    rise(1); chk("R3 toggle to 1", 1'b1); fall(1);
    rise(1); chk("R3 toggle to 0", 1'b0); fall(1);
    rise(1); chk("R3 toggle to 1 again", 1'b1); fall(1);
    sop_in = 1'b0; #2;
    rise(1); chk("R3 hold when T is 0", 1'b1); fall(1);
  endtask

  task automatic t_latch();
    setup(2'd3, 2'd0, 1'b0, 1'b0);
    sop_in = 1'b1; #2; chk("R4 closed while clock low", 1'b0);
    rise(0); chk("R4 opens on high clock", 1'b1);
    sop_in = 1'b0; #2; chk("R4 transparent while high", 1'b0);
    fall(0); chk("R4 closed after fall", 1'b0);
    sop_in = 1'b1; #2; chk("R4 holds while low", 1'b0);
    rise(0); chk("R4 reopens", 1'b1);
    fall(0);
  endtask

  task automatic t_dual();
    setup(2'd1, 2'd3, 1'b1, 1'b0);
    sop_in = 1'b1; #2;
    rise(3); chk("R6 D capture on rise", 1'b1);
    sop_in = 1'b0; #2; chk("R6 D hold while high", 1'b1);
    fall(3); chk("R6 D capture on fall", 1'b0);
    sop_in = 1'b1; #2;
    rise(3); chk("R6 D capture on next rise", 1'b1);
    fall(3); chk("R6 D capture 1 on fall", 1'b1);
    setup(2'd2, 2'd3, 1'b1, 1'b0);
    sop_in = 1'b1; #2;
    rise(3); chk("R6 T toggle on rise", 1'b1);
    fall(3); chk("R6 T toggle on fall", 1'b0);
    rise(3); chk("R6 T toggle on second rise", 1'b1);
    fall(3); chk("R6 T toggle on second fall", 1'b0);
    setup(2'd2, 2'd3, 1'b0, 1'b0);
    sop_in = 1'b1; #2;
    rise(3); chk("R6 single edge T rise", 1'b1);
    fall(3); chk("R6 single edge T ignores fall", 1'b1);
  endtask

  task automatic t_enable();
    setup(2'd1, 2'd0, 1'b0, 1'b0);
    clk_en = 1'b0; sop_in = 1'b1; #2;
    rise(0); chk("R8 D blocked", 1'b0); fall(0);
    clk_en = 1'b1; #2;
    rise(0); chk("R8 D captures after enable", 1'b1); fall(0);
    setup(2'd2, 2'd0, 1'b0, 1'b0);
    clk_en = 1'b0; sop_in = 1'b1; #2;
    rise(0); chk("R8 T blocked", 1'b0); fall(0);
    setup(2'd3, 2'd0, 1'b0, 1'b0);
    clk_en = 1'b0; #2;
    rise(0);
    sop_in = 1'b1; #2; chk("R8 latch stays closed", 1'b0);
    fall(0);
    clk_en = 1'b1; #2;
  endtask

  task automatic t_async();
    setup(2'd1, 2'd0, 1'b0, 1'b0);
    sop_in = 1'b1; #2; rise(0); fall(0);
    chk("R9 loaded 1 before reset", 1'b1);
    cell_reset = 1'b1; #1; chk("R9 cell reset clears", 1'b0);
    cell_reset = 1'b0; #1; chk("R9 stays 0 after reset", 1'b0);
    cell_preset = 1'b1; #1; chk("R10 cell preset sets", 1'b1);
    glb_reset = 1'b1; #1; chk("R10 reset beats preset", 1'b0);
    glb_reset = 1'b0; #1; chk("R10 preset resumes after reset", 1'b1);
    sop_in = 1'b0; #2; rise(0); chk("R10 preset overrides capture", 1'b1);
    fall(0);
    cell_preset = 1'b0; #1; chk("R10 value kept after preset", 1'b1);
    rise(0); chk("R2 capture after preset release", 1'b0); fall(0);
    glb_preset = 1'b1; #1; chk("R10 global preset sets", 1'b1);
    glb_preset = 1'b0; #1;
    setup(2'd3, 2'd0, 1'b0, 1'b0);
    rise(0); sop_in = 1'b1; #2; chk("R4 latch open before reset", 1'b1);
    glb_reset = 1'b1; #1; chk("R9 reset beats open latch", 1'b0);
    glb_reset = 1'b0; #1; chk("R9 latch follows after reset", 1'b1);
    fall(0);
  endtask

  initial begin
    cks = '0; por_n = 1'b0; init_val = 1'b1;
    cfg_mode = 2'd1; cfg_clk_pick = 2'd0; cfg_both_edges = 1'b0; cfg_fast_in = 1'b0;
    sop_in = 1'b0; pin_in = 1'b0; clk_en = 1'b1;
    glb_reset = 1'b0; glb_preset = 1'b0; cell_reset = 1'b0; cell_preset = 1'b0;
    #5;
    t_powerup();
    t_bypass();
    t_fast();
    t_dff();
    t_pick();
    t_tff();
    t_latch();
    t_dual();
    t_enable();
    t_async();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule